// File: doc/BRIEF.md
# Coprocessor Slave Bus Protocol Engine

This block is the bus-facing sequencer of a coprocessor that sits beside a host CPU on a shared 16-bit data bus. The host runs every transfer. It sets a two-bit status code, pulls a shared active-low strobe low, and then releases it. The engine samples the strobe on its own clock and acts on each edge. On a falling edge it captures the status code. On a rising edge it takes in write data. A protocol begins when the host broadcasts a slave ID that matches the engine's parameter. The host then sends the operation word, which arrives with its two bytes exchanged, followed by the operands as 16-bit words.

The engine does not decode the operation word itself. It presents the word on a small lookup port and gets back the byte length of each operand, the result length, a compare flag and an invalid flag. A length of zero marks an operand that lives in a coprocessor register, so that operand never crosses the bus. Once the last operand has arrived, an execution stub with a fixed latency runs. The stub sums the operand words modulo 2^16. When it finishes, the engine pulls the strobe low for exactly one clock. The host then reads a status word and, if the operation produced one, the result words.

The bus has no back-pressure. The strobe is the only transfer qualifier. The host must hold the strobe low for at least two clocks and high for at least two clocks between transfers, and must keep the write data stable until the strobe has been seen high.

Top module: `cop_slave_engine`

## Requirements
- R1: After reset the engine does not pull the strobe, does not drive the data bus, and waits for an ID broadcast.
- R2: A broadcast (code 11) whose data bits 7:0 differ from SLAVE_ID leaves the engine idle. Later transfers then produce no completion pulse and no read data.
- R3: The first code-01 write after a matching ID is the operation word. Bus bits 15:8 become its bits 7:0 and bus bits 7:0 become its bits 15:8. The lookup port presents the word with its normal byte order restored.
- R4: A word that belongs to a 1-byte operand contributes only bus bits 7:0. The engine treats bits 15:8 of that word as zero.
- R5: A 2-byte operand takes one code-01 write. A 4-byte operand takes two and an 8-byte operand takes four, least significant word first. Operand A comes before operand B. An operand of length 0 takes no transfer.
- R6: Execution starts once the last operand has been taken (or straight after the operation word when no operand is needed). It lasts EXEC_LAT clocks. It ends with the engine pulling the strobe low for exactly one clock.
- R7: The status word is read with code 10 after the completion pulse. Bit 0 is the quit flag and equals the lookup's invalid flag. For a compare without quit, bit 6 (Z) is set when the sum is zero and bit 7 (N) equals sum bit 15. Bit 2 (L) and every other bit read as zero.
- R8: During a read the engine drives the bus only while the strobe is low, and releases it as soon as the strobe goes high.
- R9: After the status read, the result is read with code-01 reads. The number of reads is 1 for a 1- or 2-byte result, 2 for 4 bytes and 4 for 8 bytes. Read k returns sum+k. After the last read the engine goes idle.
- R10: A new ID broadcast during any protocol cancels it. It also clears the accumulated operand sum.
- R11: A transfer whose code does not fit the current state (code 00, or a code other than 01/10 expected there) is ignored and leaves the state unchanged.
- R12: When the quit flag is set, the status read ends the protocol and no result reads are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_code | input | 2 | Bus status code from host |
| strobe_in | input | 1 | Level of the shared strobe line |
| strobe_pull | output | 1 | 1 pulls the strobe line low (open drain) |
| bus_in | input | 16 | Data bus as seen by the engine |
| bus_out | output | 16 | Read data for the bus |
| bus_oe | output | 1 | Bus driver enable |
| dec_opword | output | 16 | Operation word, byte order restored |
| dec_len_a | input | 4 | Byte length of operand A (0, 1, 2, 4 or 8) |
| dec_len_b | input | 4 | Byte length of operand B |
| dec_len_res | input | 4 | Byte length of result |
| dec_compare | input | 1 | Operation is a compare |
| dec_invalid | input | 1 | Operation must quit |

## Verification
Most sequencer errors show up as a missing or misplaced completion pulse. A wrong operand count or a lost state shows either no strobe pulse within a few clocks of EXEC_LAT or a pulse too early. The bench measures the pulse window on every vector. Wrong masking, word ordering or abort handling changes the sum, and that becomes visible in the status and result words read right after the pulse. A wrong read state shows at the bus enable during the very next strobe-low period.

// File: rtl/cse_pkg.sv
package cse_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_OPW, S_OPND, S_EXEC, S_DONE, S_RES
  } seq_state_t;

  localparam logic [1:0] ST_RSVD  = 2'b00;
  localparam logic [1:0] ST_XFER  = 2'b01;
  localparam logic [1:0] ST_STAT  = 2'b10;
  localparam logic [1:0] ST_BCAST = 2'b11;

  localparam int QUIT_BIT = 0;
  localparam int LT_BIT   = 2;
  localparam int ZERO_BIT = 6;
  localparam int NEG_BIT  = 7;

  // bus words needed for an operand of the given byte length
  function automatic logic [3:0] words_for(input logic [3:0] nbytes);
    if (nbytes == 4'd0)      return 4'd0;
    else if (nbytes <= 4'd2) return 4'd1;
    else                     return nbytes >> 1;
  endfunction
endpackage

// File: rtl/cse_strobe.sv
module cse_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  input  logic pulse_req,
  output logic fall,
  output logic rise,
  output logic strobe_pull
);
  logic strb_q, pull_q, mask;

  // own pulse and the clock after it are hidden from edge detection
  assign mask = strobe_pull | pull_q;
  assign fall = strb_q & ~strobe_in & ~mask;
  assign rise = ~strb_q & strobe_in & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q      <= 1'b1;
      strobe_pull <= 1'b0;
      pull_q      <= 1'b0;
    end else begin
      strb_q      <= strobe_in;
      strobe_pull <= pulse_req;
      pull_q      <= strobe_pull;
    end
  end

  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_pull |=> !strobe_pull); // R6
endmodule

// File: rtl/cse_exec_stub.sv
module cse_exec_stub #(
  parameter int DW  = 16,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          op_valid,
  input  logic [DW-1:0] op_data,
  input  logic          start,
  output logic [DW-1:0] acc,
  output logic          done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= (cnt_q == CW'(1));
      if (clr) begin
        acc   <= '0;
        cnt_q <= '0;
        done  <= 1'b0;
      end else begin
        if (op_valid) acc <= acc + op_data;
        if (start) cnt_q <= CW'(LAT);
        else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
endmodule

// File: rtl/cse_seq.sv
module cse_seq
  import cse_pkg::*;
#(
  parameter logic [7:0] SLAVE_ID = 8'hA6,
  parameter int DW   = 16,
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fall,
  input  logic            rise,
  input  logic [1:0]      st_in,
  input  logic [DW-1:0]   bus_in,
  input  logic [LENW-1:0] len_a,
  input  logic [LENW-1:0] len_b,
  input  logic [LENW-1:0] len_res,
  input  logic            is_cmp,
  input  logic            is_bad,
  input  logic            exec_done,
  input  logic [DW-1:0]   acc,
  output logic [DW-1:0]   opword,
  output logic            op_valid,
  output logic [DW-1:0]   op_data,
  output logic            exec_start,
  output logic            exec_clr,
  output logic            pulse_req,
  output logic            rd_active,
  output logic [DW-1:0]   rd_data
);
  localparam int HALF = DW / 2;

  seq_state_t state_q;
  logic [1:0]      st_lat_q;
  logic [LENW-1:0] cnt_q, rcnt_q;
  logic [LENW-1:0] wa, wb, wr, total;
  logic            byte_op;
  logic [DW-1:0]   status;

  assign wa    = words_for(len_a);
  assign wb    = words_for(len_b);
  assign wr    = words_for(len_res);
  assign total = wa + wb;

  assign byte_op  = (cnt_q < wa) ? (len_a == LENW'(1)) : (len_b == LENW'(1));
  assign op_data  = byte_op ? {{HALF{1'b0}}, bus_in[HALF-1:0]} : bus_in;
  assign op_valid = rise && st_lat_q == ST_XFER && state_q == S_OPND && cnt_q < total;
  assign exec_clr = rise && st_lat_q == ST_BCAST;
  assign pulse_req = state_q == S_EXEC && exec_done;

  always_comb begin
    status = '0;
    status[QUIT_BIT] = is_bad;
    if (is_cmp && !is_bad) begin
      status[ZERO_BIT] = (acc == '0);
      status[NEG_BIT]  = acc[DW-1];
      status[LT_BIT]   = 1'b0;
    end
  end

  assign rd_data = (state_q == S_DONE) ? status : acc + DW'(rcnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      st_lat_q   <= ST_RSVD;
      cnt_q      <= '0;
      rcnt_q     <= '0;
      opword     <= '0;
      rd_active  <= 1'b0;
      exec_start <= 1'b0;
    end else begin
      exec_start <= 1'b0;
      if (fall) begin
        st_lat_q <= st_in;
        if ((st_in == ST_STAT && state_q == S_DONE) ||
            (st_in == ST_XFER && state_q == S_RES))
          rd_active <= 1'b1;
      end else if (rise) begin
        rd_active <= 1'b0;
        if (st_lat_q == ST_BCAST) begin
          state_q <= (bus_in[HALF-1:0] == SLAVE_ID) ? S_OPW : S_IDLE;
          cnt_q   <= '0;
          rcnt_q  <= '0;
        end else begin
          case (state_q)
            S_OPW: if (st_lat_q == ST_XFER) begin
              opword  <= {bus_in[HALF-1:0], bus_in[DW-1:HALF]};
              state_q <= S_OPND;
            end
            S_OPND: if (op_valid) cnt_q <= cnt_q + LENW'(1);
            S_DONE: if (st_lat_q == ST_STAT) begin
              state_q <= (!is_bad && wr != '0) ? S_RES : S_IDLE;
            end
            S_RES: if (st_lat_q == ST_XFER) begin
              rcnt_q <= rcnt_q + LENW'(1);
              if (rcnt_q + LENW'(1) >= wr) state_q <= S_IDLE;
            end
            default: ;
          endcase
        end
      end else if (state_q == S_OPND && cnt_q == total) begin
        state_q    <= S_EXEC;
        exec_start <= 1'b1;
      end else if (pulse_req) begin
        state_q <= S_DONE;
      end
    end
  end

  AST_READ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> (state_q == S_DONE || state_q == S_RES)); // R8
  AST_OPND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_OPND |-> cnt_q <= total); // R5
  AST_PULSE_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |=> state_q == S_DONE); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && st_lat_q == ST_BCAST && bus_in[HALF-1:0] != SLAVE_ID) |=> state_q == S_IDLE); // R10
  AST_NO_RES_ON_QUIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_RES |-> !is_bad); // R12
endmodule

// File: rtl/cop_slave_engine.sv
module cop_slave_engine #(
  parameter logic [7:0] SLAVE_ID = 8'hA6,
  parameter int DW       = 16,
  parameter int LENW     = 4,
  parameter int EXEC_LAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      st_code,
  input  logic            strobe_in,
  output logic            strobe_pull,
  input  logic [DW-1:0]   bus_in,
  output logic [DW-1:0]   bus_out,
  output logic            bus_oe,
  output logic [DW-1:0]   dec_opword,
  input  logic [LENW-1:0] dec_len_a,
  input  logic [LENW-1:0] dec_len_b,
  input  logic [LENW-1:0] dec_len_res,
  input  logic            dec_compare,
  input  logic            dec_invalid
);
  logic fall, rise, pulse_req, rd_active;
  logic op_valid, exec_start, exec_clr, exec_done;
  logic [DW-1:0] op_data, acc, rd_data;

  cse_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .pulse_req(pulse_req),
    .fall(fall), .rise(rise), .strobe_pull(strobe_pull)
  );

  cse_seq #(.SLAVE_ID(SLAVE_ID), .DW(DW), .LENW(LENW)) u_seq (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .st_in(st_code),
    .bus_in(bus_in), .len_a(dec_len_a), .len_b(dec_len_b), .len_res(dec_len_res),
    .is_cmp(dec_compare), .is_bad(dec_invalid), .exec_done(exec_done), .acc(acc),
    .opword(dec_opword), .op_valid(op_valid), .op_data(op_data),
    .exec_start(exec_start), .exec_clr(exec_clr), .pulse_req(pulse_req),
    .rd_active(rd_active), .rd_data(rd_data)
  );

  cse_exec_stub #(.DW(DW), .LAT(EXEC_LAT)) u_exec (
    .clk(clk), .rst_n(rst_n), .clr(exec_clr), .op_valid(op_valid),
    .op_data(op_data), .start(exec_start), .acc(acc), .done(exec_done)
  );

  assign bus_oe  = rd_active & ~strobe_in;
  assign bus_out = rd_data;

  AST_NO_DRIVE_DURING_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_pull |-> !bus_oe); // R8
endmodule

// File: tb/sim_cop_slave_engine.sv
`timescale 1ns/1ps
module sim_cop_slave_engine;
  localparam logic [7:0] ID = 8'hA6;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] st = 2'b00;
  logic host_low = 1'b0;
  logic [15:0] bus_drv = '0;
  logic strobe_pull, bus_oe, strobe_pin;
  logic [15:0] bus_out, dec_opword;
  logic [3:0] len_a, len_b, len_res;
  logic is_cmp, is_bad;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign strobe_pin = !(host_low || strobe_pull);

  function automatic logic [3:0] code_bytes(input logic [2:0] c);
    case (c)
      3'd1: return 4'd1;
      3'd2: return 4'd2;
      3'd3: return 4'd4;
      3'd4: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int nwords(input logic [3:0] b);
    return (b == 0) ? 0 : (b <= 2) ? 1 : int'(b) / 2;
  endfunction

  // lookup table the bench provides: fields of the operation word
  always_comb begin
    len_a   = code_bytes(dec_opword[2:0]);
    len_b   = code_bytes(dec_opword[5:3]);
    len_res = code_bytes(dec_opword[8:6]);
    is_cmp  = dec_opword[9];
    is_bad  = dec_opword[10];
  end

  cop_slave_engine #(.SLAVE_ID(ID), .EXEC_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .st_code(st), .strobe_in(strobe_pin),
    .strobe_pull(strobe_pull), .bus_in(bus_drv), .bus_out(bus_out), .bus_oe(bus_oe),
    .dec_opword(dec_opword), .dec_len_a(len_a), .dec_len_b(len_b),
    .dec_len_res(len_res), .dec_compare(is_cmp), .dec_invalid(is_bad)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer_wr(input logic [1:0] code, input logic [15:0] d);
    @(negedge clk); st = code; bus_drv = d; host_low = 1'b1;
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer_rd(input logic [1:0] code, output logic [15:0] d,
                         output logic oe_low, output logic oe_after);
    @(negedge clk); st = code; host_low = 1'b1;
    repeat (2) @(negedge clk);
    d = bus_out; oe_low = bus_oe;
    host_low = 1'b0;
    #1 oe_after = bus_oe;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_pulse(output int cyc, output logic seen, output logic width_ok);
    cyc = 0; seen = 1'b0; width_ok = 1'b0;
    while (!strobe_pull && cyc < 40) begin @(negedge clk); cyc++; end
    if (strobe_pull) begin
      seen = 1'b1;
      @(negedge clk);
      width_ok = !strobe_pull;
    end
  endtask

  // stimulus table: {operation word, base of operand words}
  localparam logic [31:0] VEC [0:6] = '{
    32'h0091_AB12, 32'h0123_1000, 32'h0212_8001, 32'h0200_0000,
    32'h0202_F000, 32'h0492_0303, 32'h00C0_0000
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, op, base, sum, raw, exp_st;
    logic oe_low, oe_after, seen, wok;
    int cyc, wa, wb;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pull after reset", {31'b0, strobe_pull}, 0);
    check("R1 oe after reset", {31'b0, bus_oe}, 0);

    // R2: foreign ID
    xfer_wr(2'b11, 16'h005A);
    xfer_wr(2'b01, 16'h0002);
    wait_pulse(cyc, seen, wok);
    check("R2 no pulse on foreign id", {31'b0, seen}, 0);
    xfer_rd(2'b10, d, oe_low, oe_after);
    check("R2 no read drive", {31'b0, oe_low}, 0);

    for (int v = 0; v < 7; v++) begin
      op = VEC[v][31:16]; base = VEC[v][15:0];
      xfer_wr(2'b11, {8'h00, ID});
      xfer_wr(2'b01, {op[7:0], op[15:8]});
      check("R3 opword swap", {16'b0, dec_opword}, {16'b0, op});
      wa = nwords(code_bytes(op[2:0])); wb = nwords(code_bytes(op[5:3]));
      sum = '0;
      for (int i = 0; i < wa + wb; i++) begin
        raw = base + 16'(i) * 16'h1111;
        xfer_wr(2'b01, raw);
        if ((i < wa && code_bytes(op[2:0]) == 1) || (i >= wa && code_bytes(op[5:3]) == 1))
          sum = sum + {8'h00, raw[7:0]};
        else
          sum = sum + raw;
      end
      wait_pulse(cyc, seen, wok);
      check("R6 pulse seen", {31'b0, seen}, 1);
      check("R6 pulse width one clock", {31'b0, wok}, 1);
      check("R6 pulse after latency", {31'b0, (cyc >= LAT && cyc <= LAT + 4)}, 1);
      exp_st = '0;
      if (op[10]) exp_st[0] = 1'b1;
      else if (op[9]) begin exp_st[6] = (sum == 0); exp_st[7] = sum[15]; end
      xfer_rd(2'b10, d, oe_low, oe_after);
      check("R7 R4 R5 status word", {16'b0, d}, {16'b0, exp_st});
      check("R8 drive while low", {31'b0, oe_low}, 1);
      check("R8 release on high", {31'b0, oe_after}, 0);
      if (op[10]) begin
        xfer_rd(2'b01, d, oe_low, oe_after);
        check("R12 no result after quit", {31'b0, oe_low}, 0);
      end else begin
        for (int k = 0; k < nwords(code_bytes(op[8:6])); k++) begin
          xfer_rd(2'b01, d, oe_low, oe_after);
          check("R9 R4 R5 result word", {16'b0, d}, {16'b0, sum + 16'(k)});
          check("R9 result drive", {31'b0, oe_low}, 1);
        end
        xfer_rd(2'b01, d, oe_low, oe_after);
        check("R9 idle after results", {31'b0, oe_low}, 0);
      end
    end

    // R10: abort mid-operands, new protocol with zero operands sees cleared sum
    xfer_wr(2'b11, {8'h00, ID});
    xfer_wr(2'b01, 16'h1200);
    xfer_wr(2'b01, 16'h7777);
    xfer_wr(2'b11, {8'h00, ID});
    xfer_wr(2'b01, 16'h0002);
    wait_pulse(cyc, seen, wok);
    check("R10 pulse after abort", {31'b0, seen}, 1);
    xfer_rd(2'b10, d, oe_low, oe_after);
    check("R10 sum cleared by broadcast", {16'b0, d}, 32'h0040);

    // R11: mismatched codes ignored
    xfer_wr(2'b11, {8'h00, ID});
    xfer_wr(2'b01, 16'h1202);
    xfer_rd(2'b10, d, oe_low, oe_after);
    check("R11 status read in operand phase", {31'b0, oe_low}, 0);
    xfer_wr(2'b00, 16'h1234);
    xfer_wr(2'b01, 16'h0001);
    xfer_wr(2'b01, 16'hFFFF);
    wait_pulse(cyc, seen, wok);
    check("R11 pulse after ignored codes", {31'b0, seen}, 1);
    xfer_wr(2'b01, 16'h5555);
    xfer_wr(2'b00, 16'h4321);
    xfer_rd(2'b10, d, oe_low, oe_after);
    check("R11 status unchanged", {16'b0, d}, 32'h0040);

    // R1: reset mid-protocol
    xfer_wr(2'b11, {8'h00, ID});
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    xfer_wr(2'b01, 16'h0002);
    wait_pulse(cyc, seen, wok);
    check("R1 idle after reset", {31'b0, seen}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule